// File: doc/BRIEF.md
# Memory DLL-Off Mode Switch Sequencer

This block sits on the controller side of a DDR3-style memory interface. It moves the attached device from DLL-on to DLL-off operation. The two modes allow clock rates that do not overlap, so the clock can only be changed while the device is in self refresh. The sequencer therefore runs a fixed chain of commands, each separated by a programmable wait:

1. Turn the DLL off through a mode-register write.
2. Enter self refresh.
3. Ask the clock generator for the new frequency.
4. Wait until that clock has been stable long enough.
5. Exit self refresh.
6. Reprogram the mode registers for DLL-off operation.
7. Issue a long ZQ calibration.

The surrounding controller pulses `start_req` only when the device is quiet: all banks precharged, timings met, termination off. It reports that state on `dev_idle`. The controller also supplies the wait lengths as cycle counts.

The sequencer emits one-cycle command strobes. When a mode-register strobe is high, it also gives a register select and a data word. It holds `busy` while the chain runs and raises `done` when the chain is finished. It reports the read latency that results once the DLL is off. In that mode the read strobe starts one cycle earlier than the usual additive-plus-CAS latency.

Top module: `dlloff_seq`

## Requirements
- R1: A `start_req` seen while idle (or done) with `dev_idle` low is refused. `start_err` is high for exactly the next cycle. No command is issued, and `busy` stays low.
- R2: An accepted start (`start_req` and `dev_idle` both high while idle or done) issues a mode-register write in the next cycle. That write has `mr_sel`=1, bit 0 of `mr_data`=1 (DLL off), and bits 9, 6 and 2 all 0 (nominal termination off).
- R3: `sr_enter` is issued exactly `cfg_mod_wait`+1 cycles after that first write. A wait value of 0 behaves as 1, and this holds for every wait below.
- R4: `freq_req` rises exactly `cfg_sre_wait`+1 cycles after `sr_enter`. It stays high until the cycle of `sr_exit`, in which it is low.
- R5: `sr_exit` is issued once `clk_stable` has been high for `cfg_stable_wait` consecutive cycles while `freq_req` is high. It comes in the cycle after the last of those cycles. A low cycle of `clk_stable` restarts the count.
- R6: Mode-register writes follow `sr_exit` in a fixed order, each separated from the previous command as listed below.

  | Order | Gap (cycles) | `mr_sel` | Content of `mr_data` |
  |---|---|---|---|
  | 1 | `cfg_exit_wait`+1 | 2 | CAS write latency 6 (bits 5:3 = 001), dynamic termination off (bits 10:9 = 00) |
  | 2 | `cfg_mrd_wait`+1 | 0 | CAS latency 6 (bits 6:4 = 010, bit 2 = 0) |
  | 3 | `cfg_mrd_wait`+1 | 1 | Same word as the first write |
- R7: `zq_long` is issued exactly max(`cfg_mrd_wait`, `cfg_mod_wait`)+1 cycles after the last mode-register write.
- R8: `busy` is high from the cycle after an accepted start through the `zq_long` cycle. `done` is high from the next cycle until the next accepted start. `odt_hold_low` is high whenever `busy` or `done` is high.
- R9: `al_mode` is captured at the accepted start and written into `mr_data` bits 4:3 of mode register 1. Code 3 is written as 0. The captured code also sets `rd_lat` = AL + 6 − 1:

  | `al_mode` | AL (cycles) | `rd_lat` |
  |---|---|---|
  | 0 | 0 | 5 |
  | 1 | 5 (CL−1) | 10 |
  | 2 | 4 (CL−2) | 9 |
  | 3 | 0 | 5 |
- R10: A `start_req` while `busy` is high is ignored. It causes no `start_err` and no change to the command timing.
- R11: At most one of `mr_wr`, `sr_enter`, `sr_exit` and `zq_long` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin the DLL-off switch |
| dev_idle | input | 1 | Device quiet: banks precharged, timings met, termination off |
| clk_stable | input | 1 | Clock generator reports the new frequency is stable |
| al_mode | input | 2 | Additive latency code captured at start |
| cfg_mod_wait | input | CW | Wait after a mode-register write before a non-MRS command |
| cfg_sre_wait | input | CW | Wait after self-refresh entry before the frequency change |
| cfg_stable_wait | input | CW | Stable-clock cycles required before self-refresh exit |
| cfg_exit_wait | input | CW | Wait after self-refresh exit before mode-register writes |
| cfg_mrd_wait | input | CW | Wait between mode-register writes |
| mr_wr | output | 1 | Mode-register write strobe |
| mr_sel | output | 3 | Mode-register select (bank address) |
| mr_data | output | ROW_W | Mode-register data word |
| sr_enter | output | 1 | Self-refresh entry strobe |
| sr_exit | output | 1 | Self-refresh exit strobe |
| zq_long | output | 1 | Long ZQ calibration strobe |
| freq_req | output | 1 | Request to the clock generator to move to the DLL-off rate |
| odt_hold_low | output | 1 | Tells the controller to hold the termination pin low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Device is in DLL-off mode |
| start_err | output | 1 | One-cycle pulse: start refused |
| rd_lat | output | 5 | Read latency in DLL-off mode |

## Verification
The bench measures the exact cycle gap between every pair of successive commands. It uses nonzero waits, zero waits and unequal mode/MRD values, so a counter off by one, or a final wait that picks the smaller of the two values, shows up as a wrong gap. It drops `clk_stable` partway through the stable window. A design that kept counting instead of restarting would exit self refresh early. Runs with a clock that is stable from the outset catch a design that waits for a rising edge. A refused start, a start during a run, and a restart from the done state show whether the design errs, re-triggers or hangs. The register words and the reported latency are compared for every additive-latency code, which exposes a misplaced field or a latency that still uses AL+CL.

// File: rtl/dlloff_pkg.sv
package dlloff_pkg;

    localparam int CAS_LAT_OFF  = 6;
    localparam int CAS_WLAT_OFF = 6;
    localparam int LAT_W        = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MR1OFF,
        S_SRE,
        S_FREQ,
        S_SRX,
        S_MR2,
        S_MR0,
        S_MR1,
        S_ZQ,
        S_WAIT,
        S_DONE
    } seq_state_e;

    // Additive latency in cycles for a captured code (code 3 treated as 0)
    function automatic logic [LAT_W-1:0] al_cycles(input logic [1:0] code);
        case (code)
            2'd1:    al_cycles = LAT_W'(CAS_LAT_OFF - 1);
            2'd2:    al_cycles = LAT_W'(CAS_LAT_OFF - 2);
            default: al_cycles = '0;
        endcase
    endfunction

    // Field code actually written for the additive latency
    function automatic logic [1:0] al_field(input logic [1:0] code);
        al_field = (code == 2'd3) ? 2'd0 : code;
    endfunction

endpackage

// File: rtl/dlloff_wait_ctr.sv
module dlloff_wait_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt <= CW'(1));

    // R3
    load_then_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(cnt));

endmodule

// File: rtl/dlloff_mr_enc.sv
module dlloff_mr_enc
    import dlloff_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic [2:0]       sel,
    input  logic [1:0]       al_code,
    output logic [ROW_W-1:0] word,
    output logic [LAT_W-1:0] rd_lat
);
    localparam logic [2:0] CL_CODE  = 3'(CAS_LAT_OFF - 4);
    localparam logic [2:0] CWL_CODE = 3'(CAS_WLAT_OFF - 5);

    always_comb begin
        word = '0;
        case (sel)
            3'd0: word[6:4] = CL_CODE;
            3'd1: begin
                word[0]   = 1'b1;
                word[4:3] = al_field(al_code);
            end
            3'd2: word[5:3] = CWL_CODE;
            default: word = '0;
        endcase
    end

    assign rd_lat = al_cycles(al_code) + LAT_W'(CAS_LAT_OFF - 1);

endmodule

// File: rtl/dlloff_ctrl.sv
module dlloff_ctrl
    import dlloff_pkg::*;
#(
    parameter int CW    = 16,
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             dev_idle,
    input  logic             clk_stable,
    input  logic [1:0]       al_mode,
    input  logic [CW-1:0]    cfg_mod_wait,
    input  logic [CW-1:0]    cfg_sre_wait,
    input  logic [CW-1:0]    cfg_stable_wait,
    input  logic [CW-1:0]    cfg_exit_wait,
    input  logic [CW-1:0]    cfg_mrd_wait,
    input  logic             cnt_last,
    input  logic [ROW_W-1:0] mr_data,
    output logic             cnt_load,
    output logic [CW-1:0]    cnt_load_val,
    output logic             cnt_dec,
    output logic [1:0]       al_q,
    output logic             mr_wr,
    output logic [2:0]       mr_sel,
    output logic             sr_enter,
    output logic             sr_exit,
    output logic             zq_long,
    output logic             freq_req,
    output logic             odt_hold_low,
    output logic             busy,
    output logic             done,
    output logic             start_err
);
    seq_state_e st, ret;
    logic       err_q;
    logic       at_rest;
    logic [CW-1:0] ready_wait;

    assign at_rest    = (st == S_IDLE) || (st == S_DONE);
    assign ready_wait = (cfg_mrd_wait > cfg_mod_wait) ? cfg_mrd_wait : cfg_mod_wait;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            ret   <= S_IDLE;
            al_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (st)
                S_IDLE, S_DONE: begin
                    if (start_req) begin
                        if (dev_idle) begin
                            st   <= S_MR1OFF;
                            al_q <= al_mode;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                S_MR1OFF: begin st <= S_WAIT; ret <= S_SRE; end
                S_SRE:    begin st <= S_WAIT; ret <= S_FREQ; end
                S_FREQ:   if (clk_stable && cnt_last) st <= S_SRX;
                S_SRX:    begin st <= S_WAIT; ret <= S_MR2; end
                S_MR2:    begin st <= S_WAIT; ret <= S_MR0; end
                S_MR0:    begin st <= S_WAIT; ret <= S_MR1; end
                S_MR1:    begin st <= S_WAIT; ret <= S_ZQ; end
                S_ZQ:     st <= S_DONE;
                S_WAIT:   if (cnt_last) st <= ret;
                default:  st <= S_IDLE;
            endcase
        end
    end

    // Wait counter control: a command state loads the wait that follows it
    always_comb begin
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        cnt_dec      = 1'b0;
        case (st)
            S_MR1OFF: begin cnt_load = 1'b1; cnt_load_val = cfg_mod_wait; end
            S_SRE:    begin cnt_load = 1'b1; cnt_load_val = cfg_sre_wait; end
            S_SRX:    begin cnt_load = 1'b1; cnt_load_val = cfg_exit_wait; end
            S_MR2,
            S_MR0:    begin cnt_load = 1'b1; cnt_load_val = cfg_mrd_wait; end
            S_MR1:    begin cnt_load = 1'b1; cnt_load_val = ready_wait; end
            S_WAIT: begin
                if (cnt_last && ret == S_FREQ) begin
                    cnt_load     = 1'b1;
                    cnt_load_val = cfg_stable_wait;
                end else begin
                    cnt_dec = !cnt_last;
                end
            end
            S_FREQ: begin
                if (!clk_stable) begin
                    cnt_load     = 1'b1;
                    cnt_load_val = cfg_stable_wait;
                end else begin
                    cnt_dec = !cnt_last;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        case (st)
            S_MR0:   mr_sel = 3'd0;
            S_MR2:   mr_sel = 3'd2;
            default: mr_sel = 3'd1;
        endcase
    end

    assign mr_wr        = (st == S_MR1OFF) || (st == S_MR2) || (st == S_MR0) || (st == S_MR1);
    assign sr_enter     = (st == S_SRE);
    assign sr_exit      = (st == S_SRX);
    assign zq_long      = (st == S_ZQ);
    assign freq_req     = (st == S_FREQ);
    assign busy         = !at_rest;
    assign done         = (st == S_DONE);
    assign odt_hold_low = busy || done;
    assign start_err    = err_q;

    // R1
    reject_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (at_rest && start_req && !dev_idle) |=> (start_err && !busy && !mr_wr));

    // R2
    mr1_dll_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_wr && mr_sel == 3'd1) |-> (mr_data[0] && !mr_data[2] && !mr_data[6] && !mr_data[9]));

    // R4
    freq_until_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(freq_req) |-> sr_exit);

    // R5
    exit_after_stable_chk: assert property (@(posedge clk) disable iff (rst)
        sr_exit |-> $past(clk_stable));

    // R6
    mr2_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_wr && mr_sel == 3'd2) |-> (mr_data[5:3] == 3'b001 && mr_data[10:9] == 2'b00));

    // R8
    zq_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        zq_long |=> (done && !busy));

    // R11
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mr_wr, sr_enter, sr_exit, zq_long}));

endmodule

// File: rtl/dlloff_seq.sv
module dlloff_seq
    import dlloff_pkg::*;
#(
    parameter int CW    = 16,
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             dev_idle,
    input  logic             clk_stable,
    input  logic [1:0]       al_mode,
    input  logic [CW-1:0]    cfg_mod_wait,
    input  logic [CW-1:0]    cfg_sre_wait,
    input  logic [CW-1:0]    cfg_stable_wait,
    input  logic [CW-1:0]    cfg_exit_wait,
    input  logic [CW-1:0]    cfg_mrd_wait,
    output logic             mr_wr,
    output logic [2:0]       mr_sel,
    output logic [ROW_W-1:0] mr_data,
    output logic             sr_enter,
    output logic             sr_exit,
    output logic             zq_long,
    output logic             freq_req,
    output logic             odt_hold_low,
    output logic             busy,
    output logic             done,
    output logic             start_err,
    output logic [LAT_W-1:0] rd_lat
);
    logic          cnt_load, cnt_dec, cnt_last;
    logic [CW-1:0] cnt_load_val;
    logic [1:0]    al_q;

    dlloff_ctrl #(.CW(CW), .ROW_W(ROW_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .start_req(start_req), .dev_idle(dev_idle), .clk_stable(clk_stable),
        .al_mode(al_mode),
        .cfg_mod_wait(cfg_mod_wait), .cfg_sre_wait(cfg_sre_wait),
        .cfg_stable_wait(cfg_stable_wait), .cfg_exit_wait(cfg_exit_wait),
        .cfg_mrd_wait(cfg_mrd_wait),
        .cnt_last(cnt_last), .mr_data(mr_data),
        .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .cnt_dec(cnt_dec),
        .al_q(al_q),
        .mr_wr(mr_wr), .mr_sel(mr_sel),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .zq_long(zq_long),
        .freq_req(freq_req), .odt_hold_low(odt_hold_low),
        .busy(busy), .done(done), .start_err(start_err)
    );

    dlloff_wait_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst),
        .load(cnt_load), .load_val(cnt_load_val), .dec(cnt_dec),
        .last(cnt_last)
    );

    dlloff_mr_enc #(.ROW_W(ROW_W)) u_enc (
        .sel(mr_sel), .al_code(al_q),
        .word(mr_data), .rd_lat(rd_lat)
    );

endmodule

// File: tb/sim_dlloff_seq.sv
`timescale 1ns/1ps
module sim_dlloff_seq;
    localparam int CW = 16;
    localparam int ROW_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, dev_idle = 1'b0, clk_stable = 1'b0;
    logic [1:0] al_mode = 2'd0;
    logic [CW-1:0] w_mod = '0, w_sre = '0, w_stab = '0, w_exit = '0, w_mrd = '0;
    logic mr_wr, sr_enter, sr_exit, zq_long, freq_req, odt_hold_low, busy, done, start_err;
    logic [2:0] mr_sel;
    logic [ROW_W-1:0] mr_data;
    logic [4:0] rd_lat;

    always #4 clk = ~clk;

    dlloff_seq #(.CW(CW), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst(rst), .start_req(start_req), .dev_idle(dev_idle),
        .clk_stable(clk_stable), .al_mode(al_mode),
        .cfg_mod_wait(w_mod), .cfg_sre_wait(w_sre), .cfg_stable_wait(w_stab),
        .cfg_exit_wait(w_exit), .cfg_mrd_wait(w_mrd),
        .mr_wr(mr_wr), .mr_sel(mr_sel), .mr_data(mr_data),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .zq_long(zq_long),
        .freq_req(freq_req), .odt_hold_low(odt_hold_low), .busy(busy),
        .done(done), .start_err(start_err), .rd_lat(rd_lat)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // Event log filled at falling edges
    int n_mr, n_sre, n_srx, n_zq, n_err;
    int t_mr [4];
    int s_mr [4];
    int d_mr [4];
    int t_sre, t_srx, t_zq;

    always @(negedge clk) begin
        if (!rst) begin
            if (mr_wr) begin
                if (n_mr < 4) begin
                    t_mr[n_mr] = cyc; s_mr[n_mr] = int'(mr_sel); d_mr[n_mr] = int'(mr_data);
                end
                n_mr++;
            end
            if (sr_enter) begin t_sre = cyc; n_sre++; end
            if (sr_exit)  begin t_srx = cyc; n_srx++; end
            if (zq_long)  begin t_zq = cyc; n_zq++; end
            if (start_err) n_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gap1(input int n);
        return (n < 1 ? 1 : n) + 1;
    endfunction

    task automatic clear_log();
        n_mr = 0; n_sre = 0; n_srx = 0; n_zq = 0; n_err = 0;
        t_sre = -1; t_srx = -1; t_zq = -1;
        for (int i = 0; i < 4; i++) begin t_mr[i] = -1; s_mr[i] = -1; d_mr[i] = -1; end
    endtask

    // stab_mode: 0 stable from the start, 1 rises 3 cycles after request, 2 glitch
    task automatic run_seq(input int mod_w, input int sre_w, input int stab_w, input int exit_w,
                           input int mrd_w, input logic [1:0] al, input int stab_mode,
                           input bit poke_busy, input int exp_mr1, input int exp_lat);
        int ts, f, s_start, lim, rdy;
        @(negedge clk);
        clear_log();
        w_mod = CW'(mod_w); w_sre = CW'(sre_w); w_stab = CW'(stab_w);
        w_exit = CW'(exit_w); w_mrd = CW'(mrd_w); al_mode = al;
        clk_stable = (stab_mode == 0);
        dev_idle = 1'b1;
        start_req = 1'b1; ts = cyc;
        @(negedge clk);
        start_req = 1'b0;
        al_mode = 2'd0;
        // R8: busy rises with the first command
        chk(busy == 1'b1 && done == 1'b0, "R8", int'(busy), 1);
        if (poke_busy) begin
            @(negedge clk); @(negedge clk);
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        lim = 0;
        while (!freq_req && lim < 5000) begin @(negedge clk); lim++; end
        f = cyc;
        if (stab_mode == 0) s_start = f;
        else if (stab_mode == 1) begin
            repeat (3) @(negedge clk);
            clk_stable = 1'b1; s_start = cyc;
        end else begin
            clk_stable = 1'b1;
            repeat (2) @(negedge clk);
            clk_stable = 1'b0;
            repeat (2) @(negedge clk);
            clk_stable = 1'b1; s_start = cyc;
        end
        lim = 0;
        while (!done && lim < 5000) begin @(negedge clk); lim++; end

        // R2
        chk(t_mr[0] == ts + 1, "R2", t_mr[0], ts + 1);
        chk(s_mr[0] == 1 && d_mr[0] == exp_mr1, "R2", d_mr[0], exp_mr1);
        // R3
        chk(t_sre == t_mr[0] + gap1(mod_w), "R3", t_sre, t_mr[0] + gap1(mod_w));
        // R4
        chk(f == t_sre + gap1(sre_w), "R4", f, t_sre + gap1(sre_w));
        // R5
        chk(t_srx == s_start + (stab_w < 1 ? 1 : stab_w), "R5", t_srx,
            s_start + (stab_w < 1 ? 1 : stab_w));
        // R6: order 2, 0, 1 with stated gaps and words
        chk(t_mr[1] == t_srx + gap1(exit_w) && s_mr[1] == 2, "R6", t_mr[1], t_srx + gap1(exit_w));
        chk(d_mr[1] == 16'h0008, "R6", d_mr[1], 16'h0008);
        chk(t_mr[2] == t_mr[1] + gap1(mrd_w) && s_mr[2] == 0 && d_mr[2] == 16'h0020,
            "R6", d_mr[2], 16'h0020);
        chk(t_mr[3] == t_mr[2] + gap1(mrd_w) && s_mr[3] == 1 && d_mr[3] == exp_mr1,
            "R6", d_mr[3], exp_mr1);
        chk(n_mr == 4 && n_sre == 1 && n_srx == 1, "R6", n_mr, 4);
        // R7
        rdy = (mrd_w > mod_w) ? mrd_w : mod_w;
        chk(t_zq == t_mr[3] + gap1(rdy), "R7", t_zq, t_mr[3] + gap1(rdy));
        // R8
        chk(done && !busy && odt_hold_low && !freq_req, "R8", int'(done), 1);
        chk(cyc == t_zq + 1, "R8", cyc, t_zq + 1);
        // R9
        chk(int'(rd_lat) == exp_lat, "R9", int'(rd_lat), exp_lat);
        // R10
        chk(n_err == 0, "R10", n_err, 0);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mr_wr && !sr_enter && !sr_exit && !zq_long && !freq_req
            && !odt_hold_low && !start_err, "R8", int'(busy), 0);
    endtask

    task automatic t_reject();
        int ts;
        @(negedge clk);
        clear_log();
        dev_idle = 1'b0;
        start_req = 1'b1; ts = cyc;
        @(negedge clk);
        start_req = 1'b0;
        // R1
        chk(start_err == 1'b1 && cyc == ts + 1, "R1", int'(start_err), 1);
        chk(!busy && !mr_wr, "R1", int'(busy), 0);
        @(negedge clk);
        chk(start_err == 1'b0, "R1", int'(start_err), 0);
        repeat (10) @(negedge clk);
        chk(n_mr == 0 && n_sre == 0 && !busy && !done && n_err == 1, "R1", n_mr, 0);
    endtask

    task automatic t_run_basic();
        // AL code 1: MR1 = 0x0009, latency 10; start during run must be ignored (R10)
        run_seq(12, 5, 4, 20, 4, 2'd1, 1, 1'b1, 16'h0009, 10);
    endtask

    task automatic t_run_glitch_from_done();
        // Zero waits act as one; stable window restarts; AL code 2
        run_seq(0, 1, 6, 0, 7, 2'd2, 2, 1'b0, 16'h0011, 9);
    endtask

    task automatic t_run_stable_early();
        // Clock already stable; AL code 3 written as 0
        run_seq(9, 3, 2, 5, 2, 2'd3, 0, 1'b0, 16'h0001, 5);
    endtask

    task automatic t_run_al_zero();
        run_seq(3, 2, 1, 4, 3, 2'd0, 1, 1'b0, 16'h0001, 5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_reject();
        t_run_basic();
        t_run_glitch_from_done();
        t_run_stable_early();
        t_run_al_zero();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule